// File: doc/BRIEF.md
# I2C Pin General-Purpose I/O Multiplexer

This block sits between an I2C controller and its two bus pins and lets software take the pins over as general-purpose I/O. A function-select bit moves both pins together between two states. In `PINS_I2C` the controller's own open-drain drive-low requests reach the pins. In `PINS_GPIO` each pin is driven from a per-pin direction bit and a per-pin output latch. The pins stay open-drain in both states, and both pin levels can always be read back after a two-flop synchroniser. A typical use is clocking a stuck bus free by toggling the clock pin while the data pin is watched as an input.

The state machine has two transitions. `SEL_GPIO` is taken from `PINS_I2C` when the function register is written with bit 0 set. `SEL_I2C` is taken from `PINS_GPIO` when the function register is written with bit 0 clear. Any other write leaves the state unchanged.

Each output latch has two write-only update paths. A set register raises latch bits where a 1 is written. A clear register lowers latch bits where a 1 is written. Reading either of these registers returns the latches, so an update never has to read, modify and write back.

Top module: `i2c_pin_gpio_mux`

## Requirements
- R1: After reset the block is in `PINS_I2C`. Both direction bits are 0 and both output latches are 1. The function register reads 0, the direction register reads 0, and the set and clear registers read 0x0003.
- R2: In `PINS_I2C`, `scl_drive_low` equals `ctl_scl_low` and `sda_drive_low` equals `ctl_sda_low`, whatever the direction bits and latches hold.
- R3: The function register is at address 0. Writing it with bit 0 = 1 selects `PINS_GPIO` and writing it with bit 0 = 0 selects `PINS_I2C`; bits 15..1 are ignored. It reads back the select in bit 0 and zeros elsewhere.
- R4: The direction register is at address 1. Bit 0 = 1 makes the clock pin an output and bit 1 = 1 makes the data pin an output. It reads back what was written in bits 1..0.
- R5: The set register is at address 3. Writing a 1 in bit 0 or bit 1 raises the latch of the clock or data pin, and writing a 0 leaves that latch unchanged. A read returns the latches in bits 1..0.
- R6: The clear register is at address 4. Writing a 1 in bit 0 or bit 1 lowers the latch of the clock or data pin, and writing a 0 leaves that latch unchanged. A read returns the latches in bits 1..0.
- R7: In `PINS_GPIO` a pin is pulled low only when its direction bit is 1 and its latch is 0; otherwise it is released. The controller's requests have no effect in this state. A register write takes effect on the drive outputs from the clock edge that accepts the write.
- R8: The level register is at address 2. Bit 0 holds the clock pin level and bit 1 holds the data pin level. A level change is reported at the second rising edge after the change, in either state. Writes to this register have no effect.
- R9: With the clock pin as an output and the data pin as an input in `PINS_GPIO`, nine clear/set pulses on the clock pin appear on that pin and in the level register, and the data pin is never driven. Returning to `PINS_I2C` restores the controller's requests on both pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| ctl_scl_low | input | 1 | Controller request to pull the clock pin low |
| ctl_sda_low | input | 1 | Controller request to pull the data pin low |
| scl_pin | input | 1 | Sensed level of the clock pin |
| sda_pin | input | 1 | Sensed level of the data pin |
| scl_drive_low | output | 1 | Open-drain pull-low for the clock pin |
| sda_drive_low | output | 1 | Open-drain pull-low for the data pin |

## Verification
The drive mux is tried in `PINS_I2C` with all four controller request patterns while the GPIO registers hold values that would pull the pins low. This separates a correct mux from one that leaks GPIO state into I2C mode. In `PINS_GPIO` the controller requests are held high while the direction and latch combinations are walked. Writes of zeros to the set and clear registers show that only 1 bits act. External pull-downs on the modelled pins show the exact two-edge input latency in both states. The nine-pulse bit-bang sequence then exercises the path a bus recovery would use.

// File: rtl/i2c_pin_gpio_pkg.sv
package i2c_pin_gpio_pkg;

    localparam int NUM_PINS = 2;
    localparam int REG_AW   = 3;
    localparam int REG_DW   = 16;

    localparam logic [REG_AW-1:0] ADDR_FUNC  = 3'd0;
    localparam logic [REG_AW-1:0] ADDR_DIR   = 3'd1;
    localparam logic [REG_AW-1:0] ADDR_LEVEL = 3'd2;
    localparam logic [REG_AW-1:0] ADDR_SET   = 3'd3;
    localparam logic [REG_AW-1:0] ADDR_CLR   = 3'd4;

    typedef enum logic {
        PINS_I2C  = 1'b0,
        PINS_GPIO = 1'b1
    } pin_mode_e;

endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= '1;
        end else begin
            stage_q[0] <= async_in;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '1;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end

        // R8
        sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
            stage_q[s] == $past(stage_q[s-1]));
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/i2c_pin_mode_fsm.sv
module i2c_pin_mode_fsm
    import i2c_pin_gpio_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      func_wr,
    input  logic      func_bit,
    output pin_mode_e mode,
    output logic      gpio_sel
);
    pin_mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PINS_I2C: begin
                if (func_wr && func_bit) begin
                    state_d = PINS_GPIO;
                end
            end
            PINS_GPIO: begin
                if (func_wr && !func_bit) begin
                    state_d = PINS_I2C;
                end
            end
            default: state_d = PINS_I2C;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PINS_I2C;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        mode     = state_q;
        gpio_sel = 1'b0;
        unique case (state_q)
            PINS_I2C:  gpio_sel = 1'b0;
            PINS_GPIO: gpio_sel = 1'b1;
            default:   gpio_sel = 1'b0;
        endcase
    end

    // R3
    mode_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (func_wr && func_bit) |=> (state_q == PINS_GPIO));

    // R3
    mode_i2c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (func_wr && !func_bit) |=> (state_q == PINS_I2C));

    // R3
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !func_wr |=> $stable(state_q));

endmodule

// File: rtl/i2c_pin_ctrl.sv
module i2c_pin_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_wr,
    input  logic dir_bit,
    input  logic set_wr,
    input  logic clr_wr,
    input  logic hit_bit,
    output logic dir_q,
    output logic latch_q,
    output logic gpio_pull
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
        end else if (dir_wr) begin
            dir_q <= dir_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= 1'b1;
        end else if (set_wr && hit_bit) begin
            latch_q <= 1'b1;
        end else if (clr_wr && hit_bit) begin
            latch_q <= 1'b0;
        end
    end

    assign gpio_pull = dir_q & ~latch_q;

    // R5
    latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wr && hit_bit) |=> latch_q);

    // R6
    latch_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && hit_bit && !set_wr) |=> !latch_q);

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((set_wr || clr_wr) && hit_bit) |=> $stable(latch_q));

    // R7
    pull_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_q || latch_q) |-> !gpio_pull);

endmodule

// File: rtl/i2c_pin_gpio_mux.sv
module i2c_pin_gpio_mux
    import i2c_pin_gpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              ctl_scl_low,
    input  logic              ctl_sda_low,
    input  logic              scl_pin,
    input  logic              sda_pin,
    output logic              scl_drive_low,
    output logic              sda_drive_low
);
    localparam int PAD_W = REG_DW - NUM_PINS;

    pin_mode_e           mode;
    logic                gpio_sel;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] latch_q;
    logic [NUM_PINS-1:0] gpio_pull;
    logic [NUM_PINS-1:0] ctl_low;
    logic [NUM_PINS-1:0] drive_low;
    logic [NUM_PINS-1:0] level_sync;
    logic                wr_func, wr_dir, wr_set, wr_clr;
    logic                unused_wdata_hi;

    assign wr_func = reg_wr && (reg_addr == ADDR_FUNC);
    assign wr_dir  = reg_wr && (reg_addr == ADDR_DIR);
    assign wr_set  = reg_wr && (reg_addr == ADDR_SET);
    assign wr_clr  = reg_wr && (reg_addr == ADDR_CLR);
    assign unused_wdata_hi = ^reg_wdata[REG_DW-1:NUM_PINS];

    i2c_pin_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .func_wr  (wr_func),
        .func_bit (reg_wdata[0]),
        .mode     (mode),
        .gpio_sel (gpio_sel)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        i2c_pin_ctrl u_ctrl (
            .clk       (clk),
            .rst_n     (rst_n),
            .dir_wr    (wr_dir),
            .dir_bit   (reg_wdata[p]),
            .set_wr    (wr_set),
            .clr_wr    (wr_clr),
            .hit_bit   (reg_wdata[p]),
            .dir_q     (dir_q[p]),
            .latch_q   (latch_q[p]),
            .gpio_pull (gpio_pull[p])
        );
    end

    i2c_pin_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sda_pin, scl_pin}),
        .sync_out (level_sync)
    );

    assign ctl_low = {ctl_sda_low, ctl_scl_low};

    always_comb begin
        drive_low = '0;
        unique case (mode)
            PINS_I2C:  drive_low = ctl_low;
            PINS_GPIO: drive_low = gpio_pull;
            default:   drive_low = ctl_low;
        endcase
    end

    assign scl_drive_low = drive_low[0];
    assign sda_drive_low = drive_low[1];

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_FUNC:  reg_rdata = {{(REG_DW-1){1'b0}}, gpio_sel};
            ADDR_DIR:   reg_rdata = {{PAD_W{1'b0}}, dir_q};
            ADDR_LEVEL: reg_rdata = {{PAD_W{1'b0}}, level_sync};
            ADDR_SET:   reg_rdata = {{PAD_W{1'b0}}, latch_q};
            ADDR_CLR:   reg_rdata = {{PAD_W{1'b0}}, latch_q};
            default:    reg_rdata = '0;
        endcase
    end

    // R7
    gpio_ctl_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_sel && !dir_q[0]) |-> !scl_drive_low);

    // R2
    i2c_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gpio_sel |-> (scl_drive_low == ctl_scl_low && sda_drive_low == ctl_sda_low));

endmodule

// File: tb/i2c_pin_gpio_mux_tb.sv
module i2c_pin_gpio_mux_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        ctl_scl_low = 1'b0, ctl_sda_low = 1'b0;
    logic        ext_scl_low = 1'b0, ext_sda_low = 1'b0;
    logic        scl_pin, sda_pin, scl_drive_low, sda_drive_low;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    assign scl_pin = !(scl_drive_low || ext_scl_low);
    assign sda_pin = !(sda_drive_low || ext_sda_low);

    i2c_pin_gpio_mux u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ctl_scl_low(ctl_scl_low), .ctl_sda_low(ctl_sda_low),
        .scl_pin(scl_pin), .sda_pin(sda_pin),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
        reg_addr = a;
        #1;
        chk(req, int'(reg_rdata), exp);
    endtask

    task automatic drv_chk(input string req, input int exp);
        #1;
        chk(req, int'({sda_drive_low, scl_drive_low}), exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rd_chk("R1 func", 3'd0, 0);
        rd_chk("R1 dir", 3'd1, 0);
        rd_chk("R1 set", 3'd3, 3);
        rd_chk("R1 clr", 3'd4, 3);
        drv_chk("R1 drive", 0);
    endtask

    task automatic t_i2c_pass;
        wr(3'd1, 16'h0003);
        wr(3'd4, 16'h0003);
        rd_chk("R4 dir readback", 3'd1, 3);
        for (int p = 0; p < 4; p++) begin
            ctl_scl_low = p[0]; ctl_sda_low = p[1];
            drv_chk("R2 i2c follow", p);
        end
        ctl_scl_low = 1'b0; ctl_sda_low = 1'b0;
        wr(3'd3, 16'h0003);
    endtask

    task automatic t_func;
        wr(3'd0, 16'hFFFE);
        rd_chk("R3 upper bits ignored", 3'd0, 0);
        ctl_scl_low = 1'b1;
        drv_chk("R3 still i2c", 1);
        wr(3'd0, 16'h0001);
        rd_chk("R3 gpio selected", 3'd0, 1);
        drv_chk("R7 ctl ignored in gpio", 0);
        ctl_sda_low = 1'b1;
        wr(3'd1, 16'h0000);
        drv_chk("R7 inputs released", 0);
        wr(3'd1, 16'h0003);
        drv_chk("R7 outputs high latch", 0);
    endtask

    task automatic t_set_clr;
        wr(3'd4, 16'h0001);
        drv_chk("R7 scl pulled after clr", 1);
        rd_chk("R6 clr bit0", 3'd4, 2);
        wr(3'd4, 16'h0000);
        rd_chk("R6 zero write no effect", 3'd3, 2);
        wr(3'd4, 16'h0002);
        drv_chk("R6 both pulled", 3);
        wr(3'd3, 16'h0000);
        rd_chk("R5 zero write no effect", 3'd3, 0);
        wr(3'd3, 16'h0001);
        rd_chk("R5 set bit0", 3'd3, 1);
        drv_chk("R7 only sda pulled", 2);
        wr(3'd1, 16'h0001);
        drv_chk("R7 sda input releases", 0);
        wr(3'd3, 16'h0002);
        rd_chk("R5 set bit1", 3'd4, 3);
    endtask

    task automatic t_level;
        @(negedge clk);
        ext_sda_low = 1'b1;
        rd_chk("R8 level before edge", 3'd2, 3);
        @(negedge clk);
        rd_chk("R8 level after one edge", 3'd2, 3);
        @(negedge clk);
        rd_chk("R8 level after two edges gpio", 3'd2, 1);
        wr(3'd2, 16'h0000);
        rd_chk("R8 level write ignored dir", 3'd1, 1);
        rd_chk("R8 level write ignored latch", 3'd3, 3);
        rd_chk("R8 level write ignored func", 3'd0, 1);
        ext_sda_low = 1'b0;
        wr(3'd0, 16'h0000);
        ctl_scl_low = 1'b0; ctl_sda_low = 1'b0;
        ext_scl_low = 1'b1;
        @(negedge clk);
        rd_chk("R8 i2c mode one edge", 3'd2, 3);
        @(negedge clk);
        rd_chk("R8 i2c mode two edges", 3'd2, 2);
        ext_scl_low = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rd_chk("R8 release seen", 3'd2, 3);
    endtask

    task automatic t_nine_pulses;
        wr(3'd0, 16'h0001);
        wr(3'd1, 16'h0001);
        ext_sda_low = 1'b1;
        for (int i = 0; i < 9; i++) begin
            wr(3'd4, 16'h0001);
            drv_chk("R9 scl low", 1);
            @(negedge clk);
            @(negedge clk);
            rd_chk("R9 level scl low", 3'd2, 0);
            wr(3'd3, 16'h0001);
            drv_chk("R9 scl released", 0);
            @(negedge clk);
            @(negedge clk);
            rd_chk("R9 level scl high", 3'd2, 1);
        end
        ext_sda_low = 1'b0;
        ctl_scl_low = 1'b1; ctl_sda_low = 1'b1;
        wr(3'd0, 16'h0000);
        drv_chk("R9 back to i2c", 3);
        ctl_scl_low = 1'b0;
        drv_chk("R9 controller drives", 2);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_i2c_pass();
        t_func();
        t_set_clr();
        t_level();
        t_nine_pulses();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            report();
        end
    end

endmodule